// File: doc/BRIEF.md
# Ripple Bit-Slice Arithmetic and Logic Unit

This block is a word-wide arithmetic and logic unit made of identical one-bit slices. Each slice gets one bit of each operand and the carry from the slice below it. A shared 3-bit operation code selects one of five functions: bitwise AND, bitwise OR, pass the first operand, pass the second operand, or the full-adder sum. The carry from each slice goes to the next slice up, so the adder is a plain ripple chain. Codes with no function assigned return an all-zero word, which gives a cheap way to load the constant zero.

A subtract control inverts every bit of the second operand before it enters the adder path. The same control also inverts the incoming carry into slice 0, so with a carry input of 0 the unit computes A minus B in two's complement. The result word, the unsigned carry and the signed overflow are combinational. A carry flag register copies the carry on any clock edge where the flag enable is high.

Top module: `alu_bitslice`

## Requirements
- R1: Operation code 3'b000 drives the result with the bitwise AND of op_a and op_b.
- R2: Operation code 3'b001 drives the result with the bitwise OR of op_a and op_b.
- R3: Operation code 3'b010 drives the result with op_a unchanged.
- R4: Operation code 3'b011 drives the result with op_b unchanged.
- R5: With operation code 3'b100 and sub_en=0, {carry_out, result} equals op_a + op_b + carry_in, the carry being the (W+1)th sum bit.
- R6: With operation code 3'b100 and sub_en=1, result equals op_a - op_b - carry_in modulo 2^W, and carry_out is 1 exactly when op_a >= op_b + carry_in (no borrow).
- R7: Operation codes 3'b101, 3'b110 and 3'b111 give an all-zero result with carry_out=0 and ovf_signed=0.
- R8: With operation code 3'b100, ovf_signed is 1 exactly when the two's-complement result does not fit in W bits, which is when the carry into the top slice differs from the carry out of it. With any other code, ovf_signed is 0.
- R9: sub_en has no effect on result, carry_out or ovf_signed for any operation code other than 3'b100.
- R10: carry_out is 0 for every operation code other than 3'b100.
- R11: carry_flag is 0 after reset. On a rising clock edge with flag_en=1 it takes the value carry_out had before the edge. With flag_en=0 it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the carry flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into the adder (acts as a borrow when subtracting) |
| sub_en | input | 1 | 1 selects subtraction on the adder path |
| op_sel | input | 3 | Operation code |
| flag_en | input | 1 | Loads carry_flag on the next rising edge |
| result | output | W | Combinational result word |
| carry_out | output | 1 | Carry out of the top slice (adder code only) |
| ovf_signed | output | 1 | Two's-complement overflow (adder code only) |
| carry_flag | output | 1 | Registered carry |

## Verification
The result, carry and overflow are combinational. A broken slice, a wrong link in the carry chain or a bad mux leg therefore shows on the ports in the same cycle as the inputs. Faults in the carry chain need operands with long carry runs, for example all-ones plus one, and subtracting equal values. The only stored state is the carry flag. A wrong flag value becomes visible one edge later, and the flag holds that value until an edge with flag_en high.

// File: rtl/alu_bs_pkg.sv
package alu_bs_pkg;
    localparam logic [2:0] SEL_AND   = 3'b000;
    localparam logic [2:0] SEL_OR    = 3'b001;
    localparam logic [2:0] SEL_PASSA = 3'b010;
    localparam logic [2:0] SEL_PASSB = 3'b011;
    localparam logic [2:0] SEL_ADD   = 3'b100;

    typedef struct packed {
        logic carry;
    } flag_state_t;
endpackage

// File: rtl/alu_bs_slice.sv
module alu_bs_slice
    import alu_bs_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    input  logic       invert_b,
    input  logic [2:0] sel,
    output logic       y,
    output logic       cout
);
    logic b_eff;
    logic sum;

    always_comb begin
        b_eff = b ^ invert_b;
        sum   = a ^ b_eff ^ cin;
        cout  = (a & b_eff) | (b_eff & cin) | (cin & a);
        case (sel)
            SEL_AND:   y = a & b;
            SEL_OR:    y = a | b;
            SEL_PASSA: y = a;
            SEL_PASSB: y = b;
            SEL_ADD:   y = sum;
            default:   y = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_bs_chain.sv
module alu_bs_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin0,
    input  logic         invert_b,
    input  logic [2:0]   sel,
    output logic [W-1:0] y,
    output logic         carry_into_top,
    output logic         carry_out_top
);
    logic [W:0] c;

    assign c[0] = cin0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_bs_slice u_slice (
            .a        (a[i]),
            .b        (b[i]),
            .cin      (c[i]),
            .invert_b (invert_b),
            .sel      (sel),
            .y        (y[i]),
            .cout     (c[i+1])
        );
    end

    assign carry_into_top = c[W-1];
    assign carry_out_top  = c[W];
endmodule

// File: rtl/alu_bs_flags.sv
module alu_bs_flags
    import alu_bs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       c_top_in,
    input  logic       c_top_out,
    input  logic       flag_en,
    output logic       carry_out,
    output logic       ovf_signed,
    output logic       carry_flag
);
    flag_state_t st_d, st_q;
    logic        is_add;

    always_comb begin
        is_add     = (sel == SEL_ADD);
        carry_out  = is_add & c_top_out;
        ovf_signed = is_add & (c_top_in ^ c_top_out);
        st_d       = st_q;
        if (flag_en) begin
            st_d.carry = carry_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_flag = st_q.carry;
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic         sub_en,
    input  logic [2:0]   op_sel,
    input  logic         flag_en,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf_signed,
    output logic         carry_flag
);
    logic cin0;
    logic c_top_in;
    logic c_top_out;

    // Slice 0 carry: the subtract control supplies the +1, and carry_in becomes a borrow.
    assign cin0 = carry_in ^ sub_en;

    alu_bs_chain #(.W(W)) u_chain (
        .a              (op_a),
        .b              (op_b),
        .cin0           (cin0),
        .invert_b       (sub_en),
        .sel            (op_sel),
        .y              (result),
        .carry_into_top (c_top_in),
        .carry_out_top  (c_top_out)
    );

    alu_bs_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (op_sel),
        .c_top_in   (c_top_in),
        .c_top_out  (c_top_out),
        .flag_en    (flag_en),
        .carry_out  (carry_out),
        .ovf_signed (ovf_signed),
        .carry_flag (carry_flag)
    );
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         carry_in,
    input logic         sub_en,
    input logic [2:0]   op_sel,
    input logic         flag_en,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         ovf_signed,
    input logic         carry_flag
);
    logic [W:0] wide_add;
    always_comb wide_add = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};

    AST_AND_WORD:   assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b000 |-> result == (op_a & op_b));                              // R1
    AST_OR_WORD:    assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b001 |-> result == (op_a | op_b));                              // R2
    AST_PASS_A:     assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b010 |-> result == op_a);                                        // R3
    AST_PASS_B:     assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 3'b011 |-> result == op_b);                                        // R4
    AST_ADD_SUM:    assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'b100 && !sub_en) |-> {carry_out, result} == wide_add);          // R5
    AST_SUB_DIFF:   assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'b100 && sub_en) |-> result == W'(op_a - op_b - W'(carry_in)));  // R6
    AST_RSVD_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[2] && op_sel[1:0] != 2'b00 |-> (result == '0 && !ovf_signed));       // R7
    AST_NO_CARRY:   assert property (@(posedge clk) disable iff (!rst_n)
        op_sel != 3'b100 |-> (!carry_out && !ovf_signed));                           // R10
    AST_FLAG_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> carry_flag == $past(carry_out));                                 // R11
    AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable(carry_flag));                                           // R11
endmodule

bind alu_bitslice alu_bitslice_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .carry_in   (carry_in),
    .sub_en     (sub_en),
    .op_sel     (op_sel),
    .flag_en    (flag_en),
    .result     (result),
    .carry_out  (carry_out),
    .ovf_signed (ovf_signed),
    .carry_flag (carry_flag)
);

// File: tb/alu_bitslice_bench.sv
`timescale 1ns/1ps
module alu_bitslice_bench;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] res;
        logic         cy;
        logic         ov;
        logic         flg;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic         sub_en = 1'b0;
    logic [2:0]   op_sel = 3'b000;
    logic         flag_en = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         ovf_signed;
    logic         carry_flag;

    int   checks = 0;
    int   failures = 0;
    logic flag_model = 1'b0;
    exp_t sb_q[$];
    event sample_ev;

    always #4 clk = ~clk;

    alu_bitslice #(.W(W)) u_alu_bitslice (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .sub_en(sub_en), .op_sel(op_sel),
        .flag_en(flag_en), .result(result), .carry_out(carry_out),
        .ovf_signed(ovf_signed), .carry_flag(carry_flag)
    );

    // Monitor: pop expected items and compare them with the ports.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (result !== e.res || carry_out !== e.cy || ovf_signed !== e.ov
                    || carry_flag !== e.flg) begin
                    failures++;
                    $display("FAIL %s: got res=%h cy=%b ov=%b flg=%b, expected res=%h cy=%b ov=%b flg=%b",
                             e.tag, result, carry_out, ovf_signed, carry_flag,
                             e.res, e.cy, e.ov, e.flg);
                end
            end
        end
    end

    // Driver: apply one vector, push what the requirements predict, then step the clock.
    task automatic apply(input logic [2:0] sel, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input logic sb, input logic fe, input string tag);
        exp_t         e;
        logic [W-1:0] bb;
        logic [W:0]   wide;
        @(negedge clk);
        op_sel = sel; op_a = a; op_b = b; carry_in = ci; sub_en = sb; flag_en = fe;
        #1;
        e.tag = tag; e.cy = 1'b0; e.ov = 1'b0; e.flg = flag_model;
        case (sel)
            3'b000: e.res = a & b;
            3'b001: e.res = a | b;
            3'b010: e.res = a;
            3'b011: e.res = b;
            3'b100: begin
                bb   = sb ? ~b : b;
                wide = {1'b0, a} + {1'b0, bb} + (W+1)'(ci ^ sb);
                e.res = wide[W-1:0];
                e.cy  = wide[W];
                e.ov  = (a[W-1] == bb[W-1]) && (e.res[W-1] != a[W-1]);
            end
            default: e.res = '0;
        endcase
        sb_q.push_back(e);
        -> sample_ev;
        @(posedge clk);
        if (fe) flag_model = e.cy;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #20;
        // Reset state of the flag (R11)
        checks++;
        if (carry_flag !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset: got flg=%b, expected 0", carry_flag);
        end
        @(negedge clk);
        rst_n = 1'b1;

        apply(3'b000, 8'hF0, 8'h3C, 1'b0, 1'b0, 1'b0, "R1 and");
        apply(3'b000, 8'hA5, 8'hFF, 1'b1, 1'b1, 1'b0, "R1 R9 and with sub_en");
        apply(3'b001, 8'h81, 8'h18, 1'b0, 1'b0, 1'b0, "R2 or");
        apply(3'b001, 8'h0F, 8'hF0, 1'b1, 1'b1, 1'b0, "R2 R9 or with sub_en");
        apply(3'b010, 8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0, "R3 R9 pass a");
        apply(3'b011, 8'h5A, 8'hC3, 1'b1, 1'b1, 1'b0, "R4 R9 pass b");
        apply(3'b100, 8'h12, 8'h34, 1'b0, 1'b0, 1'b0, "R5 add");
        apply(3'b100, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, "R5 full carry ripple");
        apply(3'b100, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R11 flag loaded 1");
        apply(3'b100, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0, "R8 R5 neg overflow");
        apply(3'b100, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0, "R8 pos overflow");
        apply(3'b100, 8'h40, 8'h22, 1'b0, 1'b1, 1'b0, "R6 sub no borrow");
        apply(3'b100, 8'h22, 8'h40, 1'b0, 1'b1, 1'b1, "R6 sub borrow");
        apply(3'b100, 8'h55, 8'h55, 1'b0, 1'b1, 1'b0, "R6 R11 equal sub, flag 0");
        apply(3'b100, 8'h55, 8'h55, 1'b1, 1'b1, 1'b0, "R6 sub with borrow in");
        apply(3'b100, 8'h80, 8'h01, 1'b0, 1'b1, 1'b1, "R8 R6 sub overflow");
        apply(3'b101, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, "R7 R11 code 101 clears flag");
        apply(3'b110, 8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, "R7 R9 code 110");
        apply(3'b111, 8'h7F, 8'h7F, 1'b1, 1'b0, 1'b0, "R7 code 111");
        apply(3'b100, 8'hF0, 8'h20, 1'b0, 1'b0, 1'b1, "R5 carry then load");
        apply(3'b011, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, "R10 R11 pass b, flag held");
        apply(3'b000, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, "R10 and loads 0");
        apply(3'b001, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R11 flag now 0");
        for (int i = 0; i < 40; i++) begin
            apply(3'(i % 8), 8'((i * 37) ^ 8'h5C), 8'((i * 91) + 3),
                  1'(i % 3 == 0), 1'(i % 2), 1'(i % 4 == 1), "R5 R6 R8 sweep");
        end
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule